// File: doc/BRIEF.md
# Slow-Clock System Timer

This block is a memory-mapped system timer that runs on the system clock and advances on a one-cycle slow-tick enable, nominally 32768 pulses per second. A free-running real-time counter advances once every N slow ticks, where N is set by a prescaler register. The counter's default width is 20 bits. An alarm comparator raises a flag when the counter steps onto an absolute value held in the alarm register. A separate periodic interval timer counts raw slow ticks and raises its own flag each time a programmable period elapses.

The event flags gather in one status word, and reading that word clears it. Two write-only registers set and clear bits of an interrupt mask. A single level interrupt rises while any flagged event is also enabled. Software uses the alarm for one-shot events by writing "now + delta". It uses the interval timer for a fixed-rate tick. Reading the status register flushes anything pending.

Top module: `slow_timer_top`

## Requirements
- R1: After reset the counter, the status word and the mask all read 0, the prescaler reads 32768, the period reads 0 and the interrupt output is low.
- R2: The counter advances by one on every P-th slow tick, where P is the prescaler value and a value of 0 acts as 1. Writing the prescaler (offset 1) restarts the tick count. The counter wraps modulo 2^CNT_W, and CNT_W defaults to 20.
- R3: Status bit 3 (alarm) sets only when the counter steps onto the value in the alarm register (offset 2). If the alarm is written with the current count, the bit sets only after a full wrap, that is 2^CNT_W increments later.
- R4: Writing the period register (offset 0) with a value K > 0 restarts the interval timer. Status bit 0 then sets on every K-th slow tick. With K = 0 the interval timer raises no events.
- R5: Status bit 2 sets on every counter increment.
- R6: Reading the status register (offset 3) returns the pending flags and clears them. Bit 1 is reserved and always reads 0.
- R7: When an event coincides with a status read, the event's flag stays set for the next read.
- R8: Writing offset 4 sets the mask bits where the data has ones. Writing offset 5 clears the mask bits where the data has ones. Zeros leave mask bits unchanged. The mask reads back at offset 6.
- R9: The interrupt output is high exactly while some status bit is set and that bit is also set in the mask.
- R10: Writes to the read-only offsets 3 (status), 6 (mask) and 7 (counter) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle slow-clock tick enable |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a read of status clears it at this edge |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| irq | output | 1 | Level interrupt, masked status |

## Verification
The bench targets the alarm written with the live count. A design that compares levels instead of catching the step onto the value would fire at once, and one that mishandles the wrap would never fire; the bench shrinks the counter so a full wrap fits in the run. A status read in the same cycle as a counter increment is checked; a design where the clear beats the event would lose that flag. The prescaler and interval timer are tested one tick either side of their boundaries and with a zero period, to catch off-by-one reloads. Mask writes with zero bits and writes to read-only offsets are checked, to catch a design that overwrites the mask or the status word.

// File: rtl/st_pkg.sv
// Package: shared register offsets and status bit positions for the
// slow-clock system timer. Assumes a word-offset bus of 3 address bits.
package st_pkg;
    localparam int ADDR_W = 3;
    localparam int STAT_W = 4;

    localparam logic [ADDR_W-1:0] OFF_PERIOD   = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_PRESCALE = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_ALARM    = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_STATUS   = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_IRQ_SET  = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_IRQ_CLR  = 3'd5;
    localparam logic [ADDR_W-1:0] OFF_MASK     = 3'd6;
    localparam logic [ADDR_W-1:0] OFF_COUNT    = 3'd7;

    localparam int BIT_PIT = 0;
    localparam int BIT_WD  = 1;
    localparam int BIT_INC = 2;
    localparam int BIT_ALM = 3;
endpackage

// File: rtl/st_rtc.sv
// Module: prescaled real-time counter with an absolute alarm comparator.
// Assumes tick_i is a one-cycle enable. A prescaler write restarts the
// tick count and suppresses an increment in that cycle. The alarm fires
// only on the step onto the alarm value, never on a level match.
module st_rtc #(
    parameter int CNT_W = 20,
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [PRE_W-1:0] prescale_i,
    input  logic             pre_load_i,
    input  logic [CNT_W-1:0] alarm_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             inc_o,
    output logic             alarm_ev_o
);
    localparam int PW = PRE_W + 1;

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             pre_hit;

    // Decide whether this tick completes one prescaler period.
    always_comb begin
        pre_hit  = (prescale_i == '0) ||
                   ((PW'(pre_q) + PW'(1)) >= PW'(prescale_i));
        inc_o    = tick_i && !pre_load_i && pre_hit;
        cnt_next = cnt_q + CNT_W'(1);
        alarm_ev_o = inc_o && (cnt_next == alarm_i);
    end

    // Prescaler tick counter: restart on reload or on a completed period.
    always_ff @(posedge clk) begin
        if (!rst_n || pre_load_i) begin
            pre_q <= '0;
        end else if (tick_i) begin
            pre_q <= pre_hit ? '0 : pre_q + PRE_W'(1);
        end
    end

    // Real-time counter: one step per prescaler period, wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc_o) begin
            cnt_q <= cnt_next;
        end
    end

    assign cnt_o = cnt_q;

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    p_alarm_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_ev_o |=> (cnt_q == $past(alarm_i)));
endmodule

// File: rtl/st_pit.sv
// Module: periodic interval timer counting raw slow ticks. Assumes a
// period write restarts the count. A zero period disables events.
module st_pit #(
    parameter int PIT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [PIT_W-1:0] period_i,
    input  logic             load_i,
    output logic             ev_o
);
    localparam int CW = PIT_W + 1;

    logic [PIT_W-1:0] pit_q;
    logic             hit;

    // Detect the final tick of the current interval.
    always_comb begin
        hit  = (period_i != '0) && ((CW'(pit_q) + CW'(1)) >= CW'(period_i));
        ev_o = tick_i && !load_i && hit;
    end

    // Interval tick counter with restart on reload or period end.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            pit_q <= '0;
        end else if (tick_i && period_i != '0) begin
            pit_q <= hit ? '0 : pit_q + PIT_W'(1);
        end
    end

    p_pit_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (period_i == '0) |-> !ev_o);
endmodule

// File: rtl/st_regfile.sv
// Module: register file holding the configuration registers, the
// clear-on-read status word, the set/clear interrupt mask and the
// interrupt output. Assumes reads are combinational in the strobe cycle.
// An event that arrives together with a status read takes priority.
module st_regfile
    import st_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 20,
    parameter int PRE_W     = 16,
    parameter int PIT_W     = 16,
    parameter int PRE_RESET = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [STAT_W-1:0] ev_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [PIT_W-1:0]  period_o,
    output logic              period_wr_o,
    output logic [PRE_W-1:0]  prescale_o,
    output logic              prescale_wr_o,
    output logic [CNT_W-1:0]  alarm_o,
    output logic              irq_o
);
    logic [PIT_W-1:0]  period_q;
    logic [PRE_W-1:0]  prescale_q;
    logic [CNT_W-1:0]  alarm_q;
    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] mask_q;
    logic              rd_stat;

    // Decode write and status-read strobes.
    always_comb begin
        period_wr_o   = wr_en_i && (addr_i == OFF_PERIOD);
        prescale_wr_o = wr_en_i && (addr_i == OFF_PRESCALE);
        rd_stat       = rd_en_i && (addr_i == OFF_STATUS);
    end

    // Configuration registers: period, prescaler and alarm value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q   <= '0;
            prescale_q <= PRE_W'(PRE_RESET);
            alarm_q    <= '0;
        end else if (wr_en_i) begin
            if (addr_i == OFF_PERIOD)   period_q   <= wdata_i[PIT_W-1:0];
            if (addr_i == OFF_PRESCALE) prescale_q <= wdata_i[PRE_W-1:0];
            if (addr_i == OFF_ALARM)    alarm_q    <= wdata_i[CNT_W-1:0];
        end
    end

    // Status word: cleared by a read, new events ORed in after the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (rd_stat ? '0 : status_q) | ev_i;
        end
    end

    // Interrupt mask: ones set via the enable offset, ones clear via disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en_i && addr_i == OFF_IRQ_SET) begin
            mask_q <= mask_q | wdata_i[STAT_W-1:0];
        end else if (wr_en_i && addr_i == OFF_IRQ_CLR) begin
            mask_q <= mask_q & ~wdata_i[STAT_W-1:0];
        end
    end

    // Read multiplexer; write-only offsets read as zero.
    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            case (addr_i)
                OFF_PERIOD:   rdata_o[PIT_W-1:0]  = period_q;
                OFF_PRESCALE: rdata_o[PRE_W-1:0]  = prescale_q;
                OFF_ALARM:    rdata_o[CNT_W-1:0]  = alarm_q;
                OFF_STATUS:   rdata_o[STAT_W-1:0] = status_q;
                OFF_MASK:     rdata_o[STAT_W-1:0] = mask_q;
                OFF_COUNT:    rdata_o[CNT_W-1:0]  = cnt_i;
                default:      rdata_o = '0;
            endcase
        end
    end

    assign period_o   = period_q;
    assign prescale_o = prescale_q;
    assign alarm_o    = alarm_q;
    assign irq_o      = |(status_q & mask_q);

    p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_i) |=> ((status_q & $past(ev_i)) == $past(ev_i)));

    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (status_q == $past(ev_i)));

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o);

    p_ro_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == OFF_MASK) |=> (mask_q == $past(mask_q)));
endmodule

// File: rtl/slow_timer_top.sv
// Module: top of the slow-clock system timer. Wires the prescaled
// counter, the interval timer and the register file. Assumes one clock
// domain with tick_en as a one-cycle enable. The watchdog status bit is
// reserved and held at zero.
module slow_timer_top
    import st_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 20,
    parameter int PRE_W     = 16,
    parameter int PIT_W     = 16,
    parameter int PRE_RESET = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  alarm;
    logic [PRE_W-1:0]  prescale;
    logic [PIT_W-1:0]  period;
    logic              prescale_wr, period_wr;
    logic              inc_ev, alarm_ev, pit_ev;
    logic [STAT_W-1:0] events;

    st_rtc #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_rtc (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_en),
        .prescale_i(prescale), .pre_load_i(prescale_wr),
        .alarm_i(alarm), .cnt_o(cnt), .inc_o(inc_ev),
        .alarm_ev_o(alarm_ev)
    );

    st_pit #(.PIT_W(PIT_W)) u_pit (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_en),
        .period_i(period), .load_i(period_wr), .ev_o(pit_ev)
    );

    // Assemble the event vector at the status bit positions.
    always_comb begin
        events          = '0;
        events[BIT_PIT] = pit_ev;
        events[BIT_WD]  = 1'b0;
        events[BIT_INC] = inc_ev;
        events[BIT_ALM] = alarm_ev;
    end

    st_regfile #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W),
        .PIT_W(PIT_W), .PRE_RESET(PRE_RESET)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(bus_wr), .rd_en_i(bus_rd),
        .addr_i(bus_addr), .wdata_i(bus_wdata), .rdata_o(bus_rdata),
        .ev_i(events), .cnt_i(cnt), .period_o(period),
        .period_wr_o(period_wr), .prescale_o(prescale),
        .prescale_wr_o(prescale_wr), .alarm_o(alarm), .irq_o(irq)
    );
endmodule

// File: tb/slow_timer_top_tb.sv
`timescale 1ns/1ps
module slow_timer_top_tb;
    localparam int CW = 12;
    localparam int WRAP = 1 << CW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [31:0] rv;
    logic [31:0] c0;

    always #2.5 clk = ~clk;

    slow_timer_top #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset;
        rd(3'd1, rv); check("R1 prescale", rv, 32'd32768);
        rd(3'd0, rv); check("R1 period", rv, 32'd0);
        rd(3'd7, rv); check("R1 counter", rv, 32'd0);
        rd(3'd6, rv); check("R1 mask", rv, 32'd0);
        rd(3'd3, rv); check("R1 status", rv, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_prescale;
        wr(3'd1, 32'd3);
        rd(3'd7, c0);
        tick(2); rd(3'd7, rv); check("R2 no step before 3 ticks", rv, c0);
        tick(1); rd(3'd7, rv); check("R2 step on 3rd tick", rv, c0 + 1);
        tick(3); rd(3'd7, rv); check("R2 second step", rv, c0 + 2);
    endtask

    task automatic t_inc_flag;
        rd(3'd3, rv);
        tick(2); rd(3'd3, rv); check("R5 no inc flag yet", rv & 32'h4, 32'h0);
        tick(1); rd(3'd3, rv); check("R5 inc flag", rv & 32'h4, 32'h4);
        rd(3'd3, rv); check("R6 cleared by read", rv, 32'h0);
    endtask

    task automatic t_period;
        wr(3'd0, 32'd5);
        rd(3'd3, rv);
        tick(4); rd(3'd3, rv); check("R4 before period", rv & 32'h1, 32'h0);
        tick(1); rd(3'd3, rv); check("R4 on period", rv & 32'h1, 32'h1);
        tick(5); rd(3'd3, rv); check("R4 repeats", rv & 32'h1, 32'h1);
        wr(3'd0, 32'd0);
        rd(3'd3, rv);
        tick(20); rd(3'd3, rv); check("R4 zero period silent", rv & 32'h1, 32'h0);
        check("R6 wd bit reserved", rv & 32'h2, 32'h0);
    endtask

    task automatic t_alarm_near;
        wr(3'd1, 32'd1);
        rd(3'd7, c0);
        wr(3'd2, (c0 + 2) % WRAP);
        rd(3'd3, rv);
        tick(1); rd(3'd3, rv); check("R3 no early alarm", rv & 32'h8, 32'h0);
        tick(1); rd(3'd3, rv); check("R3 alarm on match", rv & 32'h8, 32'h8);
    endtask

    task automatic t_alarm_wrap;
        rd(3'd7, c0);
        wr(3'd2, c0);
        rd(3'd3, rv);
        tick(WRAP - 1); rd(3'd3, rv); check("R3 no match before wrap", rv & 32'h8, 32'h0);
        rd(3'd7, rv); check("R2 wrap count", rv, (c0 + WRAP - 1) % WRAP);
        tick(1); rd(3'd3, rv); check("R3 match after full wrap", rv & 32'h8, 32'h8);
        rd(3'd7, rv); check("R2 back to start", rv, c0);
    endtask

    task automatic t_event_wins;
        rd(3'd3, rv);
        @(negedge clk);
        tick_en = 1'b1; bus_rd = 1'b1; bus_addr = 3'd3;
        @(negedge clk);
        tick_en = 1'b0; bus_rd = 1'b0;
        rd(3'd3, rv); check("R7 event kept over read", rv & 32'h4, 32'h4);
        rd(3'd3, rv); check("R7 then cleared", rv, 32'h0);
    endtask

    task automatic t_mask_irq;
        rd(3'd7, c0);
        wr(3'd2, (c0 + 2) % WRAP);
        tick(2);
        #1 check("R9 masked off", {31'd0, irq}, 32'd0);
        wr(3'd4, 32'h8); rd(3'd6, rv); check("R8 enable set", rv, 32'h8);
        #1 check("R9 irq high", {31'd0, irq}, 32'd1);
        wr(3'd4, 32'h1); rd(3'd6, rv); check("R8 zeros keep bits", rv, 32'h9);
        wr(3'd5, 32'h8); rd(3'd6, rv); check("R8 disable clears", rv, 32'h1);
        #1 check("R9 irq low after disable", {31'd0, irq}, 32'd0);
        wr(3'd4, 32'h8);
        #1 check("R9 irq back", {31'd0, irq}, 32'd1);
        rd(3'd3, rv);
        #1 check("R9 irq low after read", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_ro_writes;
        wr(3'd3, 32'hF); rd(3'd3, rv); check("R10 status write ignored", rv, 32'h0);
        wr(3'd6, 32'h0); rd(3'd6, rv); check("R10 mask write ignored", rv, 32'h9);
        rd(3'd7, c0);
        wr(3'd7, 32'h0); rd(3'd7, rv); check("R10 counter write ignored", rv, c0);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_prescale();
        t_inc_flag();
        t_period();
        t_alarm_near();
        t_alarm_wrap();
        t_event_wins();
        t_mask_irq();
        t_ro_writes();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule